// File: doc/BRIEF.md
# Bit-Offset Sync Hunting Frame Receiver

This block sits behind a demodulator that delivers bytes of a serial bit stream without knowing where the true byte boundaries are. Within each input byte the earliest received bit is bit 0. The receiver searches the stream for a 16-bit synchronization word at every possible bit position. Once it finds the word, it rebuilds each following byte from two adjacent input bytes.

After synchronization it captures a length byte, the payload and a 2-byte check value, and writes each rebuilt byte into an external frame buffer. It then reports that the frame is complete and whether the check value is correct. While the receiver waits for a frame, an idle timer runs and can raise a timeout flag.

A frame-clear input re-arms the receiver for the next frame. All outputs change one clock after the input byte that causes them. Reset is asserted asynchronously and released through a two-stage synchronizer, so the block accepts input from the third rising edge after `rst_n` goes high.

Top module: `frame_sync_rx`

## Requirements
- R1: The bit stream is searched for the word 0xB24D, with the earliest bit as the MSB. Nothing is written before a match. The match cycle produces one write with `wr_lanes`=2'b11, `wr_addr`=0 and `wr_data`=16'h4DB2, which places 0xB2 at address 0 and 0x4D at address 1.
- R2: `rx_state` uses these encodings: 0 idle, 1 hunting, 2 length, 3 payload, 4 check, 5 full. A frame passes through them in that order, and `frame_done` is 1 exactly in state 5.
- R3: In idle, a nonzero input byte starts a hunt (state 1). A zero byte leaves the block idle.
- R4: While hunting, a zero input byte returns the block to idle and discards the bits collected so far.
- R5: `bit_offset` records how many bits of the matching input byte were used by the sync word, modulo 8. Each later byte takes the remaining bits of one input byte followed by the leading bits of the next, with the earliest bit as the MSB.
- R6: When the sync word ends on the last bit of an input byte, `bit_offset` is 0 and the next input byte, bit-reversed, is the length byte.
- R7: The length byte L is stored at address 2. Then L-1 payload bytes are stored at addresses 3 onward, followed by 2 check bytes. An L of 0 or 1 carries no payload. `frame_len` reports max(L,1)+4.
- R8: The check is a CRC with polynomial 0x1021, initial value 0, processed MSB first, over the length, payload and check bytes. `crc_good` is 1 in state 5 exactly when the remainder is zero.
- R9: In state 5, input bytes cause no write and do not change the state or `frame_len`.
- R10: `frame_clear` overrides `in_valid`. It returns the block to idle and clears `crc_good`, `frame_done`, `bit_offset`, `frame_len` and `idle_timeout` on the next cycle.
- R11: The idle timer counts clock cycles spent in idle and restarts from zero whenever idle is entered or `frame_clear` is applied. `idle_timeout` rises one cycle after the count reaches `idle_limit` and stays high until `frame_clear`.
- R12: Each rebuilt byte appears one cycle after its input byte as a single write: `wr_lanes`=2'b01, the byte in `wr_data[7:0]`, at the next address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte strobe |
| in_data | input | 8 | Input byte, bit 0 received first |
| frame_clear | input | 1 | Re-arm for the next frame |
| idle_limit | input | TMR_W | Idle timeout limit in cycles |
| wr_en | output | 1 | Frame buffer write strobe |
| wr_lanes | output | 2 | Byte lanes written (bit 1 writes address+1) |
| wr_addr | output | ADDR_W | Byte address of lane 0 |
| wr_data | output | 16 | Lane 1 in bits 15:8, lane 0 in bits 7:0 |
| frame_len | output | ADDR_W | Stored frame size in bytes |
| rx_state | output | 3 | Receiver state code |
| bit_offset | output | 3 | Bit position of the sync match |
| frame_done | output | 1 | Frame complete |
| crc_good | output | 1 | Check remainder was zero |
| idle_timeout | output | 1 | Idle limit reached |

## Verification
The bench sends frames whose sync word starts at each of the eight bit positions. A fault in the two-byte rebuild would corrupt every stored byte after the length byte, and a fault at offset 0 would take the length from the wrong input byte. Frames with L of 0 and 1 check the rule that skips the payload; a receiver that mishandled them would miscount and finish too early or too late. Further tests cover a frame with a corrupted check value, a zero byte during the hunt, bytes sent after the frame is complete, and a clear that arrives together with a valid byte. A receiver that got these wrong would report a good check on a bad frame, stay in the hunt on a zero byte, overwrite a finished frame, or store a byte on the clear cycle.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HUNT = 3'd1,
    ST_LEN  = 3'd2,
    ST_DATA = 3'd3,
    ST_CHK  = 3'd4,
    ST_FULL = 3'd5
  } rx_state_e;

  localparam logic [15:0] SYNC_WORD = 16'hB24D;
  localparam logic [15:0] CRC_POLY  = 16'h1021;

  // One byte of CRC update, MSB first
  function automatic logic [15:0] crc_byte(input logic [15:0] cin, input logic [7:0] din);
    logic [15:0] r;
    r = cin ^ {din, 8'h00};
    for (int i = 0; i < 8; i++) begin
      r = r[15] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/fsr_sync_detect.sv
module fsr_sync_detect
  import fsr_pkg::*;
(
  input  logic [15:0] sreg,
  input  logic [7:0]  cur_rev,
  output logic        hit,
  output logic [2:0]  hit_off,
  output logic [15:0] sreg_shift
);

  logic [23:0] acc;
  logic [23:0] win;

  assign acc        = {sreg, cur_rev};
  assign sreg_shift = acc[15:0];

  // Scan downward so that the earliest matching bit position wins
  always_comb begin
    hit     = 1'b0;
    hit_off = 3'd0;
    win     = '0;
    for (int k = 7; k >= 0; k--) begin
      win = acc >> (7 - k);
      if (win[15:0] == SYNC_WORD) begin
        hit     = 1'b1;
        hit_off = 3'(k + 1);
      end
    end
  end

endmodule

// File: rtl/fsr_realign.sv
module fsr_realign (
  input  logic [7:0] prev_rev,
  input  logic [7:0] cur_rev,
  input  logic [2:0] off,
  output logic [7:0] byte_out
);

  logic [15:0] pair;
  logic [2:0]  sh;
  logic [15:0] shifted;

  assign pair     = {prev_rev, cur_rev};
  assign sh       = 3'd0 - off;
  assign shifted  = pair >> sh;
  assign byte_out = shifted[7:0];

endmodule

// File: rtl/fsr_crc_acc.sv
module fsr_crc_acc
  import fsr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc_q,
  output logic [15:0] crc_nxt
);

  logic [15:0] crc_d;

  assign crc_nxt = crc_byte(crc_q, din);

  always_comb begin
    crc_d = crc_q;
    if (clr)     crc_d = '0;
    else if (en) crc_d = crc_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end

endmodule

// File: rtl/fsr_idle_timer.sv
module fsr_idle_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [TMR_W-1:0] limit,
  output logic             expired
);

  logic [TMR_W-1:0] cnt_q, cnt_d;
  logic             exp_q, exp_d;

  always_comb begin
    cnt_d = cnt_q;
    exp_d = exp_q;
    if (clr) begin
      cnt_d = '0;
      exp_d = 1'b0;
    end else if (!run) begin
      cnt_d = '0;
    end else if (!exp_q) begin
      if (cnt_q >= limit) exp_d = 1'b1;
      else                cnt_d = cnt_q + TMR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  assign expired = exp_q;

endmodule

// File: rtl/frame_sync_rx.sv
module frame_sync_rx
  import fsr_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int TMR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              frame_clear,
  input  logic [TMR_W-1:0]  idle_limit,
  output logic              wr_en,
  output logic [1:0]        wr_lanes,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [15:0]       wr_data,
  output logic [ADDR_W-1:0] frame_len,
  output logic [2:0]        rx_state,
  output logic [2:0]        bit_offset,
  output logic              frame_done,
  output logic              crc_good,
  output logic              idle_timeout
);

  localparam int BYTE_W = 8;
  localparam logic [ADDR_W-1:0] LEN_POS   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] FRAME_OVH = ADDR_W'(4);
  localparam logic [BYTE_W-1:0] CHK_BYTES = BYTE_W'(2);

  // Reset: asserted asynchronously, released synchronously
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  // Earliest bit moved to the MSB
  logic [BYTE_W-1:0] cur_rev;
  for (genvar gi = 0; gi < BYTE_W; gi++) begin : g_rev
    assign cur_rev[gi] = in_data[BYTE_W-1-gi];
  end

  rx_state_e         state_q, state_d;
  logic [15:0]       sreg_q, sreg_d;
  logic [BYTE_W-1:0] prev_q, prev_d;
  logic [2:0]        off_q, off_d;
  logic [ADDR_W-1:0] pos_q, pos_d;
  logic [BYTE_W-1:0] remain_q, remain_d;
  logic [ADDR_W-1:0] flen_q, flen_d;
  logic              good_q, good_d;
  logic              wen_q, wen_d;
  logic [1:0]        lanes_q, lanes_d;
  logic [ADDR_W-1:0] waddr_q, waddr_d;
  logic [15:0]       wdata_q, wdata_d;

  logic              hit;
  logic [2:0]        hit_off;
  logic [15:0]       sreg_shift;
  logic [BYTE_W-1:0] aligned;
  logic [BYTE_W-1:0] len_clamp;
  logic              crc_clr, crc_en;
  logic [15:0]       crc_q, crc_nxt;

  fsr_sync_detect u_detect (
    .sreg       (sreg_q),
    .cur_rev    (cur_rev),
    .hit        (hit),
    .hit_off    (hit_off),
    .sreg_shift (sreg_shift)
  );

  fsr_realign u_align (
    .prev_rev (prev_q),
    .cur_rev  (cur_rev),
    .off      (off_q),
    .byte_out (aligned)
  );

  fsr_crc_acc u_crc (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr     (crc_clr),
    .en      (crc_en),
    .din     (aligned),
    .crc_q   (crc_q),
    .crc_nxt (crc_nxt)
  );

  fsr_idle_timer #(.TMR_W(TMR_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr     (frame_clear),
    .run     (state_q == ST_IDLE),
    .limit   (idle_limit),
    .expired (idle_timeout)
  );

  assign len_clamp = (aligned <= BYTE_W'(1)) ? BYTE_W'(1) : aligned;

  always_comb begin
    state_d  = state_q;
    sreg_d   = sreg_q;
    prev_d   = prev_q;
    off_d    = off_q;
    pos_d    = pos_q;
    remain_d = remain_q;
    flen_d   = flen_q;
    good_d   = good_q;
    wen_d    = 1'b0;
    lanes_d  = 2'b01;
    waddr_d  = pos_q;
    wdata_d  = {8'h00, aligned};
    crc_clr  = 1'b0;
    crc_en   = 1'b0;
    if (frame_clear) begin
      state_d  = ST_IDLE;
      sreg_d   = '0;
      off_d    = '0;
      pos_d    = '0;
      remain_d = '0;
      flen_d   = '0;
      good_d   = 1'b0;
      crc_clr  = 1'b1;
    end else if (in_valid) begin
      case (state_q)
        ST_IDLE: begin
          if (in_data != '0) begin
            sreg_d  = {8'h00, cur_rev};
            state_d = ST_HUNT;
          end
        end
        ST_HUNT: begin
          if (in_data == '0) begin
            state_d = ST_IDLE;
            sreg_d  = '0;
          end else if (hit) begin
            state_d = ST_LEN;
            off_d   = hit_off;
            prev_d  = cur_rev;
            pos_d   = LEN_POS;
            sreg_d  = '0;
            wen_d   = 1'b1;
            lanes_d = 2'b11;
            waddr_d = '0;
            wdata_d = {SYNC_WORD[7:0], SYNC_WORD[15:8]};
            crc_clr = 1'b1;
          end else begin
            sreg_d = sreg_shift;
          end
        end
        ST_LEN: begin
          wen_d  = 1'b1;
          crc_en = 1'b1;
          prev_d = cur_rev;
          pos_d  = pos_q + ADDR_W'(1);
          flen_d = ADDR_W'(len_clamp) + FRAME_OVH;
          if (aligned <= BYTE_W'(1)) begin
            state_d  = ST_CHK;
            remain_d = CHK_BYTES;
          end else begin
            state_d  = ST_DATA;
            remain_d = aligned - BYTE_W'(1);
          end
        end
        ST_DATA: begin
          wen_d    = 1'b1;
          crc_en   = 1'b1;
          prev_d   = cur_rev;
          pos_d    = pos_q + ADDR_W'(1);
          remain_d = remain_q - BYTE_W'(1);
          if (remain_q == BYTE_W'(1)) begin
            state_d  = ST_CHK;
            remain_d = CHK_BYTES;
          end
        end
        ST_CHK: begin
          wen_d    = 1'b1;
          crc_en   = 1'b1;
          prev_d   = cur_rev;
          pos_d    = pos_q + ADDR_W'(1);
          remain_d = remain_q - BYTE_W'(1);
          if (remain_q == BYTE_W'(1)) begin
            state_d = ST_FULL;
            good_d  = (crc_nxt == 16'h0000);
          end
        end
        default: begin
          state_d = state_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q  <= ST_IDLE;
      sreg_q   <= '0;
      prev_q   <= '0;
      off_q    <= '0;
      pos_q    <= '0;
      remain_q <= '0;
      flen_q   <= '0;
      good_q   <= 1'b0;
      wen_q    <= 1'b0;
      lanes_q  <= 2'b00;
      waddr_q  <= '0;
      wdata_q  <= '0;
    end else begin
      state_q  <= state_d;
      sreg_q   <= sreg_d;
      prev_q   <= prev_d;
      off_q    <= off_d;
      pos_q    <= pos_d;
      remain_q <= remain_d;
      flen_q   <= flen_d;
      good_q   <= good_d;
      wen_q    <= wen_d;
      lanes_q  <= lanes_d;
      waddr_q  <= waddr_d;
      wdata_q  <= wdata_d;
    end
  end

  assign wr_en      = wen_q;
  assign wr_lanes   = lanes_q;
  assign wr_addr    = waddr_q;
  assign wr_data    = wdata_q;
  assign frame_len  = flen_q;
  assign rx_state   = state_q;
  assign bit_offset = off_q;
  assign frame_done = (state_q == ST_FULL);
  assign crc_good   = good_q;

endmodule

// File: rtl/frame_sync_rx_chk.sv
module frame_sync_rx_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [7:0]        in_data,
  input logic              frame_clear,
  input logic              wr_en,
  input logic [1:0]        wr_lanes,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [15:0]       wr_data,
  input logic [ADDR_W-1:0] frame_len,
  input logic [2:0]        rx_state,
  input logic              crc_good,
  input logic              idle_timeout
);

  assert_sync_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_lanes == 2'b11) |-> (wr_addr == '0 && wr_data == 16'h4DB2 && rx_state == 3'd2));

  assert_state_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_state <= 3'd5);

  assert_idle_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_state == 3'd0 && in_valid && in_data != 8'h00 && !frame_clear) |=> rx_state == 3'd1);

  assert_hunt_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_state == 3'd1 && in_valid && in_data == 8'h00 && !frame_clear) |=> rx_state == 3'd0);

  assert_addr_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_lanes == 2'b01) |-> (wr_addr >= ADDR_W'(2) && wr_addr < frame_len));

  assert_full_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_state == 3'd5 && !frame_clear) |=> (rx_state == 3'd5 && !wr_en));

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_clear |=> (rx_state == 3'd0 && !idle_timeout && !crc_good && !wr_en));

  assert_timer_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_timeout) |-> $past(rx_state) == 3'd0);

endmodule

bind frame_sync_rx frame_sync_rx_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_int_n),
  .in_valid     (in_valid),
  .in_data      (in_data),
  .frame_clear  (frame_clear),
  .wr_en        (wr_en),
  .wr_lanes     (wr_lanes),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .frame_len    (frame_len),
  .rx_state     (rx_state),
  .crc_good     (crc_good),
  .idle_timeout (idle_timeout)
);

// File: tb/frame_sync_rx_tb.sv
module frame_sync_rx_tb;
  localparam int AW = 9;
  localparam int TW = 16;
  localparam int NV = 9;
  // {corrupt, bit offset, length byte, payload seed}
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 3'd0, 8'd6,  8'h00},
    {1'b0, 3'd1, 8'd9,  8'h11},
    {1'b0, 3'd2, 8'd1,  8'h22},
    {1'b0, 3'd3, 8'd12, 8'h5A},
    {1'b1, 3'd4, 8'd4,  8'h80},
    {1'b0, 3'd5, 8'd2,  8'h33},
    {1'b0, 3'd6, 8'd16, 8'hC3},
    {1'b0, 3'd3, 8'd0,  8'h44},
    {1'b0, 3'd7, 8'd7,  8'h01}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [7:0]    in_data;
  logic          frame_clear;
  logic [TW-1:0] idle_limit;
  logic          wr_en;
  logic [1:0]    wr_lanes;
  logic [AW-1:0] wr_addr;
  logic [15:0]   wr_data;
  logic [AW-1:0] frame_len;
  logic [2:0]    rx_state;
  logic [2:0]    bit_offset;
  logic          frame_done;
  logic          crc_good;
  logic          idle_timeout;

  always #5 clk = ~clk;

  frame_sync_rx #(.ADDR_W(AW), .TMR_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .frame_clear(frame_clear), .idle_limit(idle_limit),
    .wr_en(wr_en), .wr_lanes(wr_lanes), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_len(frame_len), .rx_state(rx_state), .bit_offset(bit_offset),
    .frame_done(frame_done), .crc_good(crc_good), .idle_timeout(idle_timeout)
  );

  int total = 0;
  int bad   = 0;
  int nwr   = 0;
  logic [7:0] cap [0:511];
  logic [7:0] frm [0:63];
  logic       sb  [0:1023];
  int         nb;

  // Capture buffer writes shortly after each edge
  always @(posedge clk) begin
    #2;
    if (wr_en) begin
      cap[wr_addr] = wr_data[7:0];
      if (wr_lanes[1]) cap[wr_addr + 1] = wr_data[15:8];
      nwr++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = 8'h00;
  endtask

  task automatic do_clear();
    @(negedge clk);
    frame_clear = 1'b1;
    @(negedge clk);
    frame_clear = 1'b0;
  endtask

  task automatic push_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sb[nb] = b[i];
      nb++;
    end
  endtask

  function automatic logic [15:0] ref_crc(input int first, input int cnt);
    logic [15:0] c;
    c = 16'h0000;
    for (int i = 0; i < cnt; i++) begin
      c = c ^ {frm[first + i], 8'h00};
      for (int j = 0; j < 8; j++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    end
    return c;
  endfunction

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #2000000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n       = 1'b0;
    in_valid    = 1'b0;
    in_data     = 8'h00;
    frame_clear = 1'b0;
    idle_limit  = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Reset state (R2, R10)
    chk("R2 reset state", rx_state, 0);
    chk("R2 reset done", frame_done, 0);
    chk("R10 reset crc_good", crc_good, 0);
    chk("R10 reset frame_len", frame_len, 0);
    chk("R11 reset timeout", idle_timeout, 0);
    chk("R12 reset wr_en", wr_en, 0);

    // Vector table: one frame per entry
    for (int v = 0; v < NV; v++) begin
      logic [19:0] e;
      int p, len, n, tot, mism;
      logic [7:0] seed;
      logic [15:0] c;
      string tg;
      e    = VEC[v];
      p    = int'(e[18:16]);
      len  = int'(e[15:8]);
      seed = e[7:0];
      n    = (len <= 1) ? 0 : len - 1;
      tot  = 5 + n;
      frm[0] = 8'hB2;
      frm[1] = 8'h4D;
      frm[2] = len[7:0];
      for (int i = 0; i < n; i++) frm[3 + i] = seed + 8'(i * 37);
      c = ref_crc(2, 1 + n);
      frm[3 + n] = c[15:8];
      frm[4 + n] = c[7:0];
      if (e[19]) frm[4 + n] = frm[4 + n] ^ 8'h01;
      for (int i = 0; i < 512; i++) cap[i] = 8'h00;
      do_clear();
      nwr = 0;
      nb  = 0;
      for (int i = 0; i < 16 + p; i++) begin sb[nb] = 1'b0; nb++; end
      for (int i = 0; i < tot; i++) push_byte(frm[i]);
      push_byte(8'h00);
      while (nb % 8 != 0) begin sb[nb] = 1'b0; nb++; end
      for (int k = 0; k < nb / 8; k++) begin
        logic [7:0] b;
        for (int j = 0; j < 8; j++) b[j] = sb[8 * k + j];
        send(b);
      end
      mism = 0;
      for (int i = 0; i < tot; i++) if (cap[i] !== frm[i]) mism++;
      tg = (p == 0) ? "R6 frame bytes offset0" : "R5 frame bytes realigned";
      chk(tg, mism, 0);
      chk("R1 sync bytes", {cap[1], cap[0]}, 16'h4DB2);
      chk("R2 state full", rx_state, 5);
      chk("R2 frame_done", frame_done, 1);
      chk((p == 0) ? "R6 bit_offset" : "R5 bit_offset", bit_offset, p);
      chk("R7 frame_len", frame_len, tot);
      chk("R8 crc_good", crc_good, e[19] ? 0 : 1);
      chk("R12 write count", nwr, tot - 1);
    end

    // R9: bytes after completion are ignored
    begin
      int w0;
      int fl0;
      w0  = nwr;
      fl0 = int'(frame_len);
      send(8'hFF);
      send(8'h00);
      send(8'h4D);
      chk("R9 no write in full", nwr, w0);
      chk("R9 state held", rx_state, 5);
      chk("R9 frame_len held", frame_len, fl0);
    end

    // R3 / R4: idle entry and hunt abort
    do_clear();
    nwr = 0;
    send(8'h00);
    chk("R3 zero stays idle", rx_state, 0);
    send(8'h40);
    chk("R3 nonzero starts hunt", rx_state, 1);
    send(8'h00);
    chk("R4 zero aborts hunt", rx_state, 0);
    chk("R4 no write", nwr, 0);

    // R1 / R10: sync at offset 0, then clear together with a valid byte
    send(8'h4D);
    chk("R1 hunting before match", rx_state, 1);
    chk("R1 no write before match", nwr, 0);
    send(8'hB2);
    chk("R1 state length after match", rx_state, 2);
    chk("R1 one sync write", nwr, 1);
    @(negedge clk);
    frame_clear = 1'b1;
    in_valid    = 1'b1;
    in_data     = 8'h60;
    @(negedge clk);
    frame_clear = 1'b0;
    in_valid    = 1'b0;
    in_data     = 8'h00;
    chk("R10 clear wins state", rx_state, 0);
    chk("R10 clear wins write", nwr, 1);
    chk("R10 clear offset", bit_offset, 0);

    // R11: idle timeout exact cycle
    idle_limit = TW'(5);
    do_clear();
    repeat (5) @(negedge clk);
    chk("R11 timeout not yet", idle_timeout, 0);
    @(negedge clk);
    chk("R11 timeout raised", idle_timeout, 1);
    repeat (3) @(negedge clk);
    chk("R11 timeout sticky", idle_timeout, 1);
    do_clear();
    chk("R10 clear drops timeout", idle_timeout, 0);
    idle_limit = '1;

    finish_run();
  end

endmodule